// File: doc/BRIEF.md
# Interrupt Aggregation Register Block

This block groups thirty-two level interrupt sources behind a small word-addressed register file and combines them into one interrupt line. Each source is visible three ways: as its live level, as a sticky latch that ignores the mask, and as that latch filtered by a per-source mask. Software acknowledges a source by writing a one to its bit in a write-only clear word. A single global enable gates only the interrupt line. Sources keep latching while the line is disabled.

Two plain read/write words hold general control and test-IO settings, and their contents are driven out on ports. A read-only status word reflects an input port. Accesses are single-cycle writes and single-cycle reads, and read data is registered.

Top module: `irq_regblock`

## Requirements
- R1: Control (offset 0x00) and test-IO control (offset 0x08) are read/write words that reset to 0x00000003 and 0x00100808. Their current values drive `ctrl_out` and `testio_out`.
- R2: A read of offset 0x04 returns `status_in`. Writes to 0x04, 0x18, 0x1C and 0x20 change no state.
- R3: A read of offset 0x20 returns the `src_in` value present in the read cycle, without latching.
- R4: Offset 0x1C holds one sticky bit per source. The bit sets in any cycle its source is high, whatever the mask, and stays set until it is cleared.
- R5: Offset 0x10 is the mask and resets to 0. A read of offset 0x18 returns the sticky bits ANDed with the mask, so a mask bit of 1 lets its source through.
- R6: Writing a 1 to a bit at offset 0x14 clears that sticky bit, and writing 0 leaves it alone. A read of 0x14 returns 0.
- R7: When a source is high in the same cycle that its clear bit is written, the sticky bit stays set.
- R8: `irq_out` is registered. In each cycle it equals the global enable ANDed with the OR of the masked sticky bits, both taken as they stood in the previous cycle. With the enable at 0 the line stays low, but latching continues.
- R9: Only bit 0 of the global enable word (offset 0x0C, reset 0) is stored, and its bits 31:1 read as 0.
- R10: A read of an offset above 0x20, or of an offset whose two low bits are not zero, returns 0.
- R11: `bus_rdata` is valid in the cycle after `bus_rd`. It is 0 after a cycle with no read. A write and a read of the same word in one cycle return the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| src_in | input | 32 | Live interrupt source levels |
| status_in | input | 32 | Value shown by the read-only status word |
| ctrl_out | output | 32 | Current control word |
| testio_out | output | 32 | Current test-IO control word |
| irq_out | output | 1 | Aggregated interrupt line |

## Verification
A sticky bit that was lost or set wrongly becomes visible at the next read of offset 0x1C. If that bit is unmasked, it also shows on `irq_out` one cycle after the cycle in which the bit went wrong. A wrong mask bit or enable bit shows on the next read of its word, and on `irq_out` within a cycle once any pending bit depends on it. Live and status reads expose input wiring faults in the cycle after the read. The randomized stream reads every offset often, so a diverging state seldom goes unreported for more than a handful of cycles.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  parameter int DATA_W = 32;
  parameter int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_TESTIO = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_GEN    = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_CLR    = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_MSKPND = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_PEND   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_LIVE   = 8'h20;

  localparam logic [DATA_W-1:0] RST_CTRL   = 32'h0000_0003;
  localparam logic [DATA_W-1:0] RST_TESTIO = 32'h0010_0808;

  function automatic logic [DATA_W-1:0] masked_view(input logic [DATA_W-1:0] pend,
                                                    input logic [DATA_W-1:0] msk);
    return pend & msk;
  endfunction

  function automatic logic [DATA_W-1:0] sticky_next(input logic [DATA_W-1:0] pend,
                                                    input logic [DATA_W-1:0] clr,
                                                    input logic [DATA_W-1:0] src);
    return (pend & ~clr) | src;
  endfunction
endpackage

// File: rtl/irq_rw_word.sv
module irq_rw_word #(
  parameter int W = 32,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= RESET_VAL;
    else if (wr_en) q <= wr_data;
  end
endmodule

// File: rtl/irq_core.sv
module irq_core
  import irq_regs_pkg::*;
#(
  parameter int N = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_in,
  input  logic         gen_wr,
  input  logic         gen_d,
  input  logic         mask_wr,
  input  logic [N-1:0] mask_d,
  input  logic [N-1:0] clr_vec,
  output logic         gen_q,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] stk_q,
  output logic [N-1:0] masked,
  output logic         irq_q
);
  logic any_pending;

  assign masked      = masked_view(stk_q, mask_q);
  assign any_pending = |masked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_q  <= 1'b0;
      mask_q <= '0;
      stk_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (gen_wr)  gen_q  <= gen_d;
      if (mask_wr) mask_q <= mask_d;
      stk_q <= sticky_next(stk_q, clr_vec, src_in);
      irq_q <= gen_q & any_pending;
    end
  end

  // R4: a set bit not being cleared stays set
  p_sticky_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stk_q & $past(stk_q & ~clr_vec)) == $past(stk_q & ~clr_vec)));
  // R7: a high source always leaves its bit set, clear or not
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stk_q & $past(src_in)) == $past(src_in)));
  // R6: clearing with the source low empties the bit
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stk_q & $past(clr_vec & ~src_in)) == '0));
  // R8: disabled line stays low
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_q |=> !irq_q);
endmodule

// File: rtl/irq_regblock.sv
module irq_regblock
  import irq_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] src_in,
  input  logic [DATA_W-1:0] status_in,
  output logic [DATA_W-1:0] ctrl_out,
  output logic [DATA_W-1:0] testio_out,
  output logic              irq_out
);
  logic              wr_ctrl, wr_testio, wr_gen, wr_mask, wr_clr;
  logic [DATA_W-1:0] clr_vec;
  logic              gen_q;
  logic [DATA_W-1:0] mask_q, stk_q, masked;
  logic [DATA_W-1:0] rd_mux;

  assign wr_ctrl   = bus_wr && (bus_addr == OFF_CTRL);
  assign wr_testio = bus_wr && (bus_addr == OFF_TESTIO);
  assign wr_gen    = bus_wr && (bus_addr == OFF_GEN);
  assign wr_mask   = bus_wr && (bus_addr == OFF_MASK);
  assign wr_clr    = bus_wr && (bus_addr == OFF_CLR);
  assign clr_vec   = wr_clr ? bus_wdata : '0;

  irq_rw_word #(.W(DATA_W), .RESET_VAL(RST_CTRL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .wr_data(bus_wdata), .q(ctrl_out));

  irq_rw_word #(.W(DATA_W), .RESET_VAL(RST_TESTIO)) u_testio (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_testio), .wr_data(bus_wdata), .q(testio_out));

  irq_core #(.N(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .gen_wr(wr_gen), .gen_d(bus_wdata[0]),
    .mask_wr(wr_mask), .mask_d(bus_wdata), .clr_vec(clr_vec),
    .gen_q(gen_q), .mask_q(mask_q), .stk_q(stk_q), .masked(masked), .irq_q(irq_out));

  always_comb begin
    unique case (bus_addr)
      OFF_CTRL:   rd_mux = ctrl_out;
      OFF_STATUS: rd_mux = status_in;
      OFF_TESTIO: rd_mux = testio_out;
      OFF_GEN:    rd_mux = {{(DATA_W-1){1'b0}}, gen_q};
      OFF_MASK:   rd_mux = mask_q;
      OFF_MSKPND: rd_mux = masked;
      OFF_PEND:   rd_mux = stk_q;
      OFF_LIVE:   rd_mux = src_in;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= bus_rd ? rd_mux : '0;
  end

  // R11: no read, no data
  p_rdata_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));
  // R10: out-of-map read returns zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr > OFF_LIVE)) |=> (bus_rdata == '0));
endmodule

// File: tb/irq_regblock_bench.sv
module irq_regblock_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] src_in = '0;
  logic [31:0] status_in = 32'h001C_1C00;
  logic [31:0] ctrl_out, testio_out;
  logic        irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] m_ctrl, m_tio, m_mask, m_pend;
  logic        m_gen;

  always #2 clk = ~clk;

  irq_regblock u_irq_regblock (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .src_in(src_in), .status_in(status_in), .ctrl_out(ctrl_out),
    .testio_out(testio_out), .irq_out(irq_out));

  function automatic logic [31:0] ref_read(input logic [7:0] a, input logic [31:0] live);
    case (a)
      8'h00: return m_ctrl;
      8'h04: return status_in;
      8'h08: return m_tio;
      8'h0C: return {31'd0, m_gen};
      8'h10: return m_mask;
      8'h18: return m_pend & m_mask;
      8'h1C: return m_pend;
      8'h20: return live;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00, 8'h08: return "R1";
      8'h04: return "R2";
      8'h0C: return "R9";
      8'h10, 8'h18: return "R5";
      8'h14: return "R6";
      8'h1C: return "R4";
      8'h20: return "R3";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic reset_ref();
    m_ctrl = 32'h0000_0003; m_tio = 32'h0010_0808;
    m_mask = '0; m_pend = '0; m_gen = 1'b0;
  endtask

  // one bus cycle; inputs set at negedge, results checked at next negedge
  task automatic step(input logic [7:0] a, input logic w, input logic [31:0] d,
                      input logic r, input logic [31:0] s);
    logic [31:0] exp_rd;
    logic        exp_irq;
    bus_addr = a; bus_wr = w; bus_wdata = d; bus_rd = r; src_in = s;
    @(posedge clk);
    exp_rd  = r ? ref_read(a, s) : 32'd0;
    exp_irq = m_gen & (|(m_pend & m_mask));
    if (w) begin
      case (a)
        8'h00: m_ctrl = d;
        8'h08: m_tio  = d;
        8'h0C: m_gen  = d[0];
        8'h10: m_mask = d;
        default: ;
      endcase
    end
    m_pend = (w && a == 8'h14) ? (m_pend & ~d) : m_pend;
    m_pend = m_pend | s;
    @(negedge clk);
    check(r ? tag_of(a) : "R11", bus_rdata, exp_rd);
    check("R8", {31'd0, irq_out}, {31'd0, exp_irq});
    check("R1", ctrl_out, m_ctrl);
    check("R1", testio_out, m_tio);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    reset_ref();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset values of every word (R1, R2, R9)
    for (int k = 0; k <= 9; k++) step(8'(k * 4), 1'b0, 0, 1'b1, 0);
    // R2: writes to read-only words are ignored
    step(8'h04, 1'b1, 32'hFFFF_FFFF, 1'b0, 0);
    step(8'h1C, 1'b1, 32'hFFFF_FFFF, 1'b0, 0);
    step(8'h1C, 1'b0, 0, 1'b1, 0);
    // R9: upper enable bits not stored
    step(8'h0C, 1'b1, 32'hFFFF_FFFE, 1'b0, 0);
    step(8'h0C, 1'b0, 0, 1'b1, 0);
    // R8: latch with enable off, line stays low
    step(8'h10, 1'b1, 32'h0000_0010, 1'b0, 32'h0000_0010);
    step(8'h18, 1'b0, 0, 1'b1, 0);
    step(8'h18, 1'b0, 0, 1'b1, 0);
    step(8'h0C, 1'b1, 32'h1, 1'b0, 0);
    step(8'h00, 1'b0, 0, 1'b0, 0);
    step(8'h00, 1'b0, 0, 1'b0, 0);
    // R7: clear and set in same cycle, bit stays
    step(8'h14, 1'b1, 32'h0000_0010, 1'b0, 32'h0000_0010);
    step(8'h1C, 1'b0, 0, 1'b1, 0);
    // R6: clear with source low
    step(8'h14, 1'b1, 32'h0000_0010, 1'b1, 0);
    step(8'h1C, 1'b0, 0, 1'b1, 0);
    // R5: masked source latches but stays out of masked view
    step(8'h00, 1'b0, 0, 1'b0, 32'h8000_0000);
    step(8'h18, 1'b0, 0, 1'b1, 0);
    step(8'h1C, 1'b0, 0, 1'b1, 0);
    // R10: unaligned and above-map reads
    step(8'h21, 1'b0, 0, 1'b1, 32'h1234_5678);
    step(8'h24, 1'b0, 0, 1'b1, 0);
    step(8'hFC, 1'b0, 0, 1'b1, 0);
    // R11: same-cycle write and read return old value
    step(8'h00, 1'b1, 32'hA5A5_0001, 1'b1, 0);
    step(8'h00, 1'b0, 0, 1'b1, 0);
    // R3: live view
    step(8'h20, 1'b0, 0, 1'b1, 32'h0F0F_0000);
    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [7:0]  a;
      logic [31:0] d, s;
      logic        w, r;
      int pick = int'($urandom_range(0, 11));
      a = (pick == 10) ? 8'($urandom_range(0, 255)) :
          (pick == 11) ? 8'h14 : 8'(pick * 4);
      w = ($urandom_range(0, 3) == 0);
      r = ($urandom_range(0, 3) != 0);
      d = $urandom;
      if (a == 8'h14) d = d & $urandom;
      s = $urandom & $urandom & $urandom & $urandom;
      status_in = (i % 97 == 0) ? $urandom : status_in;
      step(a, w, d, r, s);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule